// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit maps a 16-bit logical address to a 20-bit physical address. It looks the segment up in a small table held in flip-flops. The upper bits of the logical address select one of eight segment descriptors. The lower bits are an offset into that segment. Each descriptor holds a physical base, an inclusive limit, a valid bit and two protection flags: read-only and kernel-only. The unit checks the offset against the limit and checks the access type against the flags. If both checks pass, it returns base plus offset one cycle after the request. If a check fails, it returns a zero address and a code that names the cause.

System software loads descriptors through a write port, for example when switching between processes. The table sits in registers rather than main memory, so a translation needs no extra memory access. A write reaches the table at the next clock edge. A request made in the same cycle as a write therefore still sees the old descriptor.

Top module: `seg_xlate_unit`

## Requirements
- R1: The segment number is `req_laddr[15:13]` and the offset is `req_laddr[12:0]`. On success, `rsp_paddr` equals the descriptor base plus the zero-extended offset, modulo 2^20.
- R2: A request presented with `req_valid` high is answered in the next cycle with `rsp_valid` high. In a cycle after one without a request, `rsp_valid`, `rsp_paddr` and `rsp_fault` are all zero.
- R3: The limit is inclusive. An offset equal to the limit translates. An offset larger than the limit gives `rsp_fault` = 2 (bounds).
- R4: An access to a descriptor whose valid bit is clear gives `rsp_fault` = 1 (invalid segment). Reset clears every valid bit and drives all outputs to zero.
- R5: A write (`req_write` = 1) to a read-only descriptor gives `rsp_fault` = 3 (protection). A read of the same descriptor translates normally.
- R6: A user-mode access (`req_user` = 1) to a kernel-only descriptor gives `rsp_fault` = 3. A kernel-mode access to it translates normally.
- R7: When several checks fail at once, only one cause is reported. Invalid takes precedence over bounds, and bounds takes precedence over protection.
- R8: Whenever `rsp_fault` is nonzero, `rsp_paddr` is zero. A successful translation reports `rsp_fault` = 0.
- R9: A table write with `tbl_we` high updates entry `tbl_idx` at the next clock edge. A request in the same cycle uses the previous contents. Entries at other indices are unchanged.
- R10: Writing a descriptor with `tbl_valid` = 0 invalidates it, and later accesses to it fault as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_idx | input | 3 | Descriptor index to write |
| tbl_base | input | 20 | Physical base of the descriptor |
| tbl_limit | input | 13 | Largest legal offset |
| tbl_valid | input | 1 | Descriptor valid bit |
| tbl_ro | input | 1 | Read-only flag |
| tbl_kern | input | 1 | Kernel-only flag |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | 16 | Logical address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user-mode access |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | 20 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 bounds, 3 protection |

## Verification
The bench probes the limit from both sides: an offset exactly at the limit and one just past it, plus a limit at the top of the offset range. A design with an exclusive compare would fault on the legal case, and an off-by-one would let an illegal access through. It combines failing checks to test the fault priority and the zeroed address. A design with the wrong order would report protection where bounds is expected, or leak a partial address. It also issues a request in the same cycle as a write to the same descriptor. A design that bypasses the new value would return the new base one cycle too early. Finally, it sets a base near the top of the physical range so that base plus offset wraps, which exposes any width error in the adder.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Fault causes reported on the response port.
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_BOUNDS  = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  // Picks one cause when several checks fail: invalid, then bounds, then protection.
  function automatic fault_e pick_fault(input logic seg_ok,
                                        input logic in_range,
                                        input logic perm_ok);
    if (!seg_ok)        return FLT_INVALID;
    else if (!in_range) return FLT_BOUNDS;
    else if (!perm_ok)  return FLT_PROT;
    else                return FLT_NONE;
  endfunction

  // An access is allowed unless it writes a read-only segment
  // or comes from user mode into a kernel-only segment.
  function automatic logic perm_allows(input logic is_write,
                                       input logic is_user,
                                       input logic flag_ro,
                                       input logic flag_kern);
    return !((is_write && flag_ro) || (is_user && flag_kern));
  endfunction

endpackage

// File: rtl/seg_table_regs.sv
module seg_table_regs #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 20,
  parameter int OFF_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [OFF_W-1:0] wr_limit,
  input  logic             wr_valid,
  input  logic             wr_ro,
  input  logic             wr_kern,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W-1:0] rd_limit,
  output logic             rd_valid,
  output logic             rd_ro,
  output logic             rd_kern
);

  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [OFF_W-1:0] limit_q [NSEG];
  logic [NSEG-1:0]  valid_q;
  logic [NSEG-1:0]  ro_q;
  logic [NSEG-1:0]  kern_q;
  logic [NSEG-1:0]  wr_hit;

  // One register slice per descriptor, each with its own decoded write enable.
  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    assign wr_hit[g] = wr_en && (wr_idx == SEG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        valid_q[g] <= 1'b0;
        ro_q[g]    <= 1'b0;
        kern_q[g]  <= 1'b0;
      end else if (wr_hit[g]) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
        valid_q[g] <= wr_valid;
        ro_q[g]    <= wr_ro;
        kern_q[g]  <= wr_kern;
      end
    end
  end

  // The read port returns the stored contents. It never bypasses a write in the same cycle.
  always_comb begin
    rd_base  = base_q[rd_idx];
    rd_limit = limit_q[rd_idx];
    rd_valid = valid_q[rd_idx];
    rd_ro    = ro_q[rd_idx];
    rd_kern  = kern_q[rd_idx];
  end

  // R9
  table_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_idx != $past(wr_idx)) ||
              (rd_base == $past(wr_base) && rd_limit == $past(wr_limit) &&
               rd_valid == $past(wr_valid)));

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_xlate_pkg::*;
#(
  parameter int PA_W  = 20,
  parameter int OFF_W = 13
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             is_write,
  input  logic             is_user,
  input  logic [PA_W-1:0]  ent_base,
  input  logic [OFF_W-1:0] ent_limit,
  input  logic             ent_valid,
  input  logic             ent_ro,
  input  logic             ent_kern,
  output fault_e           fault,
  output logic [PA_W-1:0]  paddr
);

  // Base plus zero-extended offset, wrapping at the width of the physical address.
  function automatic logic [PA_W-1:0] add_base(input logic [PA_W-1:0]  base,
                                               input logic [OFF_W-1:0] off);
    return base + PA_W'(off);
  endfunction

  // Named results of each check, exposed for assertions and waveforms.
  logic in_range;
  logic perm_ok;
  logic [PA_W-1:0] sum;

  assign in_range = (offset <= ent_limit);
  assign perm_ok  = perm_allows(is_write, is_user, ent_ro, ent_kern);
  assign sum      = add_base(ent_base, offset);
  assign fault    = pick_fault(ent_valid, in_range, perm_ok);
  assign paddr    = (fault == FLT_NONE) ? sum : '0;

endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  fault_e          in_fault,
  input  logic [PA_W-1:0] in_paddr,
  output logic            out_valid,
  output fault_e          out_fault,
  output logic [PA_W-1:0] out_paddr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= FLT_NONE;
      out_paddr <= '0;
    end else begin
      out_valid <= in_valid;
      out_fault <= in_valid ? in_fault : FLT_NONE;
      out_paddr <= in_valid ? in_paddr : '0;
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && out_fault == FLT_NONE && out_paddr == '0));

  // R8
  fault_paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fault != FLT_NONE) |-> (out_paddr == '0));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int LA_W  = 16,
  parameter int SEG_W = 3,
  parameter int PA_W  = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tbl_we,
  input  logic [SEG_W-1:0]      tbl_idx,
  input  logic [PA_W-1:0]       tbl_base,
  input  logic [LA_W-SEG_W-1:0] tbl_limit,
  input  logic                  tbl_valid,
  input  logic                  tbl_ro,
  input  logic                  tbl_kern,
  input  logic                  req_valid,
  input  logic [LA_W-1:0]       req_laddr,
  input  logic                  req_write,
  input  logic                  req_user,
  output logic                  rsp_valid,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [1:0]            rsp_fault
);

  localparam int OFF_W = LA_W - SEG_W;

  // Splitting the logical address into its two fields.
  function automatic logic [SEG_W-1:0] seg_of(input logic [LA_W-1:0] la);
    return la[LA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [LA_W-1:0] la);
    return la[OFF_W-1:0];
  endfunction

  logic [SEG_W-1:0] req_seg;
  logic [OFF_W-1:0] req_off;
  logic [PA_W-1:0]  ent_base;
  logic [OFF_W-1:0] ent_limit;
  logic             ent_valid;
  logic             ent_ro;
  logic             ent_kern;
  fault_e           chk_fault;
  logic [PA_W-1:0]  chk_paddr;
  fault_e           out_fault;

  assign req_seg = seg_of(req_laddr);
  assign req_off = off_of(req_laddr);

  seg_table_regs #(.SEG_W(SEG_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_base  (tbl_base),
    .wr_limit (tbl_limit),
    .wr_valid (tbl_valid),
    .wr_ro    (tbl_ro),
    .wr_kern  (tbl_kern),
    .rd_idx   (req_seg),
    .rd_base  (ent_base),
    .rd_limit (ent_limit),
    .rd_valid (ent_valid),
    .rd_ro    (ent_ro),
    .rd_kern  (ent_kern)
  );

  seg_access_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
    .offset    (req_off),
    .is_write  (req_write),
    .is_user   (req_user),
    .ent_base  (ent_base),
    .ent_limit (ent_limit),
    .ent_valid (ent_valid),
    .ent_ro    (ent_ro),
    .ent_kern  (ent_kern),
    .fault     (chk_fault),
    .paddr     (chk_paddr)
  );

  seg_resp_reg #(.PA_W(PA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_fault  (chk_fault),
    .in_paddr  (chk_paddr),
    .out_valid (rsp_valid),
    .out_fault (out_fault),
    .out_paddr (rsp_paddr)
  );

  assign rsp_fault = out_fault;

  // R5 R6: a protection fault needs a write or a user-mode access.
  prot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault == FLT_PROT) |-> $past(req_write || req_user));

  // R4: the invalid cause is only reported on a response slot.
  fault_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != FLT_NONE) |-> rsp_valid);

endmodule

// File: tb/seg_xlate_unit_tb.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [19:0] tbl_base = '0;
  logic [12:0] tbl_limit = '0;
  logic        tbl_valid = 1'b0;
  logic        tbl_ro = 1'b0;
  logic        tbl_kern = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_laddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic [19:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int errors = 0;

  // Bench-side copy of the descriptor table.
  logic [19:0] m_base  [8];
  logic [12:0] m_limit [8];
  logic        m_valid [8];
  logic        m_ro    [8];
  logic        m_kern  [8];

  always #2.5 clk = ~clk;

  seg_xlate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_base(tbl_base), .tbl_limit(tbl_limit), .tbl_valid(tbl_valid),
    .tbl_ro(tbl_ro), .tbl_kern(tbl_kern), .req_valid(req_valid),
    .req_laddr(req_laddr), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model: invalid first, then range, then permission.
  function automatic logic [1:0] ref_fault(input int s, input int off, input bit wr, input bit usr);
    if (!m_valid[s]) return 2'd1;
    if (off > int'(m_limit[s])) return 2'd2;
    if ((wr && m_ro[s]) || (usr && m_kern[s])) return 2'd3;
    return 2'd0;
  endfunction

  task automatic load(input int s, input logic [19:0] b, input logic [12:0] l,
                      input bit v, input bit ro, input bit kern);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(s); tbl_base = b; tbl_limit = l;
    tbl_valid = v; tbl_ro = ro; tbl_kern = kern;
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[s] = b; m_limit[s] = l; m_valid[s] = v; m_ro[s] = ro; m_kern[s] = kern;
  endtask

  // Issues one request and checks the response against the model.
  task automatic xlate(input string req, input int s, input int off, input bit wr, input bit usr);
    logic [1:0]  ef;
    logic [19:0] ea;
    ef = ref_fault(s, off, wr, usr);
    ea = (ef == 2'd0) ? 20'(m_base[s] + 20'(off)) : 20'd0;
    @(negedge clk);
    req_valid = 1'b1; req_laddr = {3'(s), 13'(off)}; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " fault"}, 32'(rsp_fault), 32'(ef));
    check({req, " paddr"}, 32'(rsp_paddr), 32'(ea));
  endtask

  task automatic t_reset;
    check("R4 reset valid", 32'(rsp_valid), 0);
    check("R4 reset paddr", 32'(rsp_paddr), 0);
    check("R4 reset fault", 32'(rsp_fault), 0);
    xlate("R4 empty table", 4, 12, 0, 0);
  endtask

  task automatic t_basic;
    load(1, 20'h12000, 13'h0FF, 1, 0, 0);
    xlate("R1 basic", 1, 'h34, 0, 1);
    xlate("R1 write", 1, 'h00, 1, 1);
    @(negedge clk);
    check("R2 idle valid", 32'(rsp_valid), 0);
    check("R2 idle paddr", 32'(rsp_paddr), 0);
  endtask

  task automatic t_limit;
    xlate("R3 at limit", 1, 'h0FF, 0, 0);
    xlate("R3 past limit", 1, 'h100, 0, 0);
    load(2, 20'h40000, 13'h1FFF, 1, 1, 0);
    xlate("R3 max limit", 2, 'h1FFF, 0, 0);
  endtask

  task automatic t_prot;
    xlate("R5 ro write", 2, 'h10, 1, 0);
    xlate("R5 ro read", 2, 'h10, 0, 1);
    load(3, 20'h80000, 13'h010, 1, 0, 1);
    xlate("R6 user to kernel seg", 3, 'h4, 0, 1);
    xlate("R6 kernel access", 3, 'h4, 1, 0);
  endtask

  task automatic t_priority;
    load(4, 20'h05000, 13'h020, 1, 1, 1);
    xlate("R7 bounds over prot", 4, 'h21, 1, 1);
    load(5, 20'h06000, 13'h002, 0, 1, 1);
    xlate("R7 invalid over bounds", 5, 'h100, 1, 1);
    xlate("R8 fault zero addr", 4, 'h5, 1, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'd1; tbl_base = 20'h30000; tbl_limit = 13'h0FF;
    tbl_valid = 1'b1; tbl_ro = 1'b0; tbl_kern = 1'b0;
    req_valid = 1'b1; req_laddr = {3'd1, 13'h5}; req_write = 1'b0; req_user = 1'b0;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    check("R9 same cycle uses old base", 32'(rsp_paddr), 32'h12005);
    m_base[1] = 20'h30000;
    xlate("R9 new base next cycle", 1, 5, 0, 0);
    xlate("R9 other entry kept", 2, 'h7, 0, 0);
  endtask

  task automatic t_wrap_and_clear;
    load(7, 20'hFFFF0, 13'h1FFF, 1, 0, 0);
    xlate("R1 wrap", 7, 'h20, 0, 0);
    load(7, 20'hFFFF0, 13'h1FFF, 0, 0, 0);
    xlate("R10 cleared entry", 7, 'h20, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 1'b0; m_ro[i] = 1'b0; m_kern[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_limit();
    t_prot();
    t_priority();
    t_same_cycle();
    t_wrap_and_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule